// File: doc/BRIEF.md
# Word-Packed Serial Receiver with Idle Timeout

This block receives asynchronous serial characters (one start bit, eight data bits sent least significant bit first, no parity, one stop bit). It collects them four at a time into 32-bit words and queues the words in a small word FIFO. A consumer reads the FIFO through a show-ahead read port: it sees the head word and pops it with a one-cycle read strobe.

The consumer organises reception into transfers. Pulsing `arm_valid` with a non-zero `arm_count` arms a transfer. A transfer closes in one of two ways:

- The armed number of characters has arrived since the previous close.
- The idle-timeout event is enabled and no character has arrived for `stale_limit` character times while at least one character is outstanding.

On either close, any partly filled word goes into the FIFO with its unused upper bytes zero. The number of characters in that transfer is latched into `snap_count`, and `xfer_done` pulses for one cycle. An idle-timeout close also raises a sticky `stale_irq` flag.

Single-cycle command strobes control the block:

| Code | Action |
|------|--------|
| 1 | Flush the receive path |
| 2 | Clear the overrun flag |
| 3 | Enable the idle-timeout event |
| 4 | Disable the idle-timeout event |
| 5 | Clear `stale_irq` |

Software re-arms with the sequence disable, clear, arm, enable.

Top module: `wrx_core`

## Requirements
- R1: With CLKS_PER_OSR clocks per oversampling tick, one bit lasts 16·CLKS_PER_OSR clocks. A frame is a low start bit, eight data bits least significant first, and a high stop bit. Each bit is sampled once, near its middle.
- R2: A low pulse that is no longer low half a bit after it was detected starts no character. A frame whose stop bit is sampled low is discarded.
- R3: Characters are packed four per word, the earliest in bits 7:0 and each later one a byte higher. A word enters the FIFO when its fourth character completes.
- R4: After `arm_valid` with a non-zero count N, the transfer closes on the Nth character since the previous close. On that close a partial word is pushed with zero upper bytes, `snap_count` becomes N, `xfer_done` pulses once and the block disarms.
- R5: When the idle-timeout event is enabled, at least one character is outstanding and no character has arrived for `stale_limit` character times (160 oversampling ticks each), the transfer closes. A partial word, if any, is pushed zero-padded, `snap_count` takes the outstanding count, `xfer_done` pulses and `stale_irq` is set.
- R6: While the idle-timeout event is disabled (code 4, and the state after reset), outstanding characters never close a transfer. Enabling it (code 3) lets the timeout close the transfer later.
- R7: `stale_irq` stays set until command code 5 clears it.
- R8: `rx_ready` is high exactly while the FIFO holds a word. `rd_data` shows the oldest word, and `rd_en` removes it.
- R9: A character that completes while the FIFO already holds FIFO_DEPTH words sets `overrun`, and a word pushed in that state is lost. `overrun` stays set until command code 2 clears it.
- R10: Command code 1 empties the FIFO, discards any partial word and the outstanding count, and disarms. It leaves `overrun` and `stale_irq` unchanged.
- R11: After reset, `rx_ready`, `overrun`, `stale_irq` and `xfer_done` are low and `snap_count` is zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rxd | input | 1 | Serial receive line, idle high |
| cmd_valid | input | 1 | Command strobe |
| cmd_code | input | 3 | Command: 1 flush, 2 clear overrun, 3 enable timeout, 4 disable timeout, 5 clear stale flag |
| arm_valid | input | 1 | Load `arm_count` and arm a transfer |
| arm_count | input | CNT_W | Expected characters in the transfer (0 = count close disabled) |
| stale_limit | input | STALE_W | Idle timeout in character times |
| rd_en | input | 1 | Pop the head FIFO word |
| rd_data | output | 32 | Head FIFO word |
| rx_ready | output | 1 | FIFO holds at least one word |
| overrun | output | 1 | Sticky overrun flag |
| stale_irq | output | 1 | Sticky idle-timeout flag |
| xfer_done | output | 1 | One-cycle pulse when a transfer closes |
| snap_count | output | CNT_W | Characters in the last closed transfer |

## Verification
Most internal faults in this block become visible within one transfer.

- A wrong byte lane or a stale packing buffer shows up in the next word read from `rd_data`, either as a misplaced byte or as non-zero padding.
- A wrong character counter shows up as a wrong `snap_count`, or as a transfer that closes a character early or late.
- A faulty idle timer either raises `stale_irq` while the timeout is disabled or nothing is outstanding, or leaves it low long after the programmed number of character times.
- Sampling-phase faults corrupt the bits of the very next character, or let a short glitch produce a character.

// File: rtl/wrx_pkg.sv
package wrx_pkg;
    localparam int OSR_RATE   = 16;
    localparam int FRAME_BITS = 10;
    localparam int LANES      = 4;

    typedef logic [31:0] word_t;

    typedef enum logic [2:0] {
        CMD_NOP       = 3'd0,
        CMD_RST_RX    = 3'd1,
        CMD_RST_ERR   = 3'd2,
        CMD_STALE_EN  = 3'd3,
        CMD_STALE_DIS = 3'd4,
        CMD_STALE_CLR = 3'd5
    } cmd_e;

    typedef struct packed {
        logic       valid;
        logic [7:0] data;
    } rx_byte_t;

    typedef struct packed {
        logic  push;
        word_t data;
    } push_t;

    // Place one character into the given byte lane of a word.
    function automatic word_t put_lane(word_t w, logic [1:0] lane, logic [7:0] b);
        word_t r;
        r = w;
        r[{lane, 3'b000} +: 8] = b;
        return r;
    endfunction
endpackage

// File: rtl/wrx_bitrx.sv
module wrx_bitrx
    import wrx_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     flush,
    input  logic     osr_tick,
    input  logic     rxd,
    output rx_byte_t byte_o
);
    localparam logic [3:0] HALF_LAST = 4'(OSR_RATE / 2 - 1);
    localparam logic [3:0] FULL_LAST = 4'(OSR_RATE - 1);

    typedef enum logic [1:0] {S_IDLE, S_START, S_DATA, S_STOP} st_e;

    logic [1:0] sync_q;
    st_e        st_q;
    logic [3:0] tick_q;
    logic [2:0] bit_q;
    logic [7:0] shf_q;
    rx_byte_t   byte_q;
    logic       line;

    assign line   = sync_q[1];
    assign byte_o = byte_q;

    // Two-flop synchroniser for the asynchronous line.
    always_ff @(posedge clk) begin
        if (rst) sync_q <= 2'b11;
        else     sync_q <= {sync_q[0], rxd};
    end

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            st_q   <= S_IDLE;
            tick_q <= '0;
            bit_q  <= '0;
            shf_q  <= '0;
            byte_q <= '0;
        end else begin
            byte_q.valid <= 1'b0;
            if (osr_tick) begin
                unique case (st_q)
                    S_IDLE: begin
                        if (!line) begin
                            st_q   <= S_START;
                            tick_q <= '0;
                        end
                    end
                    S_START: begin
                        if (tick_q == HALF_LAST) begin
                            tick_q <= '0;
                            bit_q  <= '0;
                            st_q   <= line ? S_IDLE : S_DATA;
                        end else begin
                            tick_q <= tick_q + 4'd1;
                        end
                    end
                    S_DATA: begin
                        if (tick_q == FULL_LAST) begin
                            tick_q <= '0;
                            shf_q  <= {line, shf_q[7:1]};
                            if (bit_q == 3'd7) st_q <= S_STOP;
                            else               bit_q <= bit_q + 3'd1;
                        end else begin
                            tick_q <= tick_q + 4'd1;
                        end
                    end
                    S_STOP: begin
                        if (tick_q == FULL_LAST) begin
                            tick_q <= '0;
                            st_q   <= S_IDLE;
                            if (line) begin
                                byte_q.valid <= 1'b1;
                                byte_q.data  <= shf_q;
                            end
                        end else begin
                            tick_q <= tick_q + 4'd1;
                        end
                    end
                    default: st_q <= S_IDLE;
                endcase
            end
        end
    end
endmodule

// File: rtl/wrx_fifo.sv
module wrx_fifo
    import wrx_pkg::*;
#(
    parameter int DEPTH = 4
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  flush,
    input  logic  push,
    input  word_t push_data,
    input  logic  pop,
    output word_t head,
    output logic  empty,
    output logic  full
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = AW + 1;

    word_t         mem [DEPTH];
    logic [AW-1:0] wp_q, rp_q;
    logic [CW-1:0] cnt_q;
    logic          do_push, do_pop;

    assign empty   = (cnt_q == '0);
    assign full    = (cnt_q == CW'(DEPTH));
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign head    = mem[rp_q];

    always_ff @(posedge clk) begin
        if (do_push) mem[wp_q] <= push_data;
    end

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            wp_q  <= '0;
            rp_q  <= '0;
            cnt_q <= '0;
        end else begin
            if (do_push) wp_q <= wp_q + AW'(1);
            if (do_pop)  rp_q <= rp_q + AW'(1);
            unique case ({do_push, do_pop})
                2'b10:   cnt_q <= cnt_q + CW'(1);
                2'b01:   cnt_q <= cnt_q - CW'(1);
                default: cnt_q <= cnt_q;
            endcase
        end
    end
endmodule

// File: rtl/wrx_stale.sv
module wrx_stale
    import wrx_pkg::*;
#(
    parameter int STALE_W = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               flush,
    input  logic               osr_tick,
    input  logic               run,
    input  logic               restart,
    input  logic [STALE_W-1:0] limit,
    output logic               fire
);
    localparam int CHAR_TICKS = OSR_RATE * FRAME_BITS;
    localparam int SUB_W      = $clog2(CHAR_TICKS);

    logic [SUB_W-1:0]   sub_q;
    logic [STALE_W-1:0] chars_q;

    assign fire = run && !restart && (limit != '0) && (chars_q == limit);

    always_ff @(posedge clk) begin
        if (rst || flush || !run || restart || fire) begin
            sub_q   <= '0;
            chars_q <= '0;
        end else if (osr_tick) begin
            if (sub_q == SUB_W'(CHAR_TICKS - 1)) begin
                sub_q   <= '0;
                chars_q <= chars_q + STALE_W'(1);
            end else begin
                sub_q <= sub_q + SUB_W'(1);
            end
        end
    end
endmodule

// File: rtl/wrx_xfer.sv
module wrx_xfer
    import wrx_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             flush,
    input  rx_byte_t         byte_i,
    input  logic             stale_fire,
    input  logic             arm_valid,
    input  logic [CNT_W-1:0] arm_count,
    output push_t            push_o,
    output logic             pending,
    output logic             done,
    output logic [CNT_W-1:0] snap
);
    word_t            buf_q;
    logic [1:0]       lane_q;
    logic [CNT_W-1:0] cnt_q, target_q, snap_q, cnt_next;
    logic             armed_q, done_q, count_hit;
    word_t            filled;

    assign cnt_next  = cnt_q + CNT_W'(1);
    assign count_hit = byte_i.valid && armed_q && (cnt_next == target_q);
    assign filled    = put_lane(buf_q, lane_q, byte_i.data);
    assign pending   = (cnt_q != '0);
    assign done      = done_q;
    assign snap      = snap_q;

    always_comb begin
        push_o = '0;
        if (byte_i.valid) begin
            push_o.push = (lane_q == 2'd3) || count_hit;
            push_o.data = filled;
        end else if (stale_fire) begin
            push_o.push = (lane_q != 2'd0);
            push_o.data = buf_q;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            snap_q <= '0;
        end else if (!flush) begin
            if (count_hit)                        snap_q <= cnt_next;
            else if (stale_fire && !byte_i.valid) snap_q <= cnt_q;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            buf_q    <= '0;
            lane_q   <= '0;
            cnt_q    <= '0;
            target_q <= '0;
            armed_q  <= 1'b0;
            done_q   <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (arm_valid) begin
                target_q <= arm_count;
                armed_q  <= (arm_count != '0);
            end
            if (byte_i.valid) begin
                if (lane_q == 2'd3 || count_hit) begin
                    buf_q  <= '0;
                    lane_q <= '0;
                end else begin
                    buf_q  <= filled;
                    lane_q <= lane_q + 2'd1;
                end
                if (count_hit) begin
                    cnt_q   <= '0;
                    armed_q <= 1'b0;
                    done_q  <= 1'b1;
                end else begin
                    cnt_q <= cnt_next;
                end
            end else if (stale_fire) begin
                buf_q   <= '0;
                lane_q  <= '0;
                cnt_q   <= '0;
                armed_q <= 1'b0;
                done_q  <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/wrx_core.sv
module wrx_core
    import wrx_pkg::*;
#(
    parameter int CLKS_PER_OSR = 2,
    parameter int FIFO_DEPTH   = 4,
    parameter int CNT_W        = 16,
    parameter int STALE_W      = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               rxd,
    input  logic               cmd_valid,
    input  logic [2:0]         cmd_code,
    input  logic               arm_valid,
    input  logic [CNT_W-1:0]   arm_count,
    input  logic [STALE_W-1:0] stale_limit,
    input  logic               rd_en,
    output logic [31:0]        rd_data,
    output logic               rx_ready,
    output logic               overrun,
    output logic               stale_irq,
    output logic               xfer_done,
    output logic [CNT_W-1:0]   snap_count
);
    logic     osr_tick;
    rx_byte_t rx_byte;
    push_t    push_req;
    logic     rx_byte_valid, fifo_full, fifo_empty;
    logic     pending, stale_fire;
    logic     stale_en_q, stale_irq_q, overrun_q;
    logic     cmd_rst_rx, cmd_rst_err, cmd_st_en, cmd_st_dis, cmd_st_clr;
    cmd_e     cmd;

    assign cmd         = cmd_e'(cmd_code);
    assign cmd_rst_rx  = cmd_valid && (cmd == CMD_RST_RX);
    assign cmd_rst_err = cmd_valid && (cmd == CMD_RST_ERR);
    assign cmd_st_en   = cmd_valid && (cmd == CMD_STALE_EN);
    assign cmd_st_dis  = cmd_valid && (cmd == CMD_STALE_DIS);
    assign cmd_st_clr  = cmd_valid && (cmd == CMD_STALE_CLR);

    generate
        if (CLKS_PER_OSR <= 1) begin : g_nodiv
            assign osr_tick = 1'b1;
        end else begin : g_div
            localparam int DIV_W = $clog2(CLKS_PER_OSR);
            logic [DIV_W-1:0] div_q;
            always_ff @(posedge clk) begin
                if (rst || div_q == DIV_W'(CLKS_PER_OSR - 1)) div_q <= '0;
                else                                          div_q <= div_q + DIV_W'(1);
            end
            assign osr_tick = (div_q == DIV_W'(CLKS_PER_OSR - 1));
        end
    endgenerate

    wrx_bitrx u_bitrx (
        .clk      (clk),
        .rst      (rst),
        .flush    (cmd_rst_rx),
        .osr_tick (osr_tick),
        .rxd      (rxd),
        .byte_o   (rx_byte)
    );

    assign rx_byte_valid = rx_byte.valid;

    wrx_stale #(.STALE_W(STALE_W)) u_stale (
        .clk      (clk),
        .rst      (rst),
        .flush    (cmd_rst_rx),
        .osr_tick (osr_tick),
        .run      (stale_en_q && pending),
        .restart  (rx_byte_valid),
        .limit    (stale_limit),
        .fire     (stale_fire)
    );

    wrx_xfer #(.CNT_W(CNT_W)) u_xfer (
        .clk        (clk),
        .rst        (rst),
        .flush      (cmd_rst_rx),
        .byte_i     (rx_byte),
        .stale_fire (stale_fire),
        .arm_valid  (arm_valid),
        .arm_count  (arm_count),
        .push_o     (push_req),
        .pending    (pending),
        .done       (xfer_done),
        .snap       (snap_count)
    );

    wrx_fifo #(.DEPTH(FIFO_DEPTH)) u_fifo (
        .clk       (clk),
        .rst       (rst),
        .flush     (cmd_rst_rx),
        .push      (push_req.push),
        .push_data (push_req.data),
        .pop       (rd_en),
        .head      (rd_data),
        .empty     (fifo_empty),
        .full      (fifo_full)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            stale_en_q  <= 1'b0;
            stale_irq_q <= 1'b0;
            overrun_q   <= 1'b0;
        end else begin
            if (cmd_st_en)       stale_en_q <= 1'b1;
            else if (cmd_st_dis) stale_en_q <= 1'b0;

            if (cmd_st_clr)      stale_irq_q <= 1'b0;
            else if (stale_fire && !cmd_rst_rx) stale_irq_q <= 1'b1;

            if (cmd_rst_err)     overrun_q <= 1'b0;
            else if (rx_byte_valid && fifo_full && !cmd_rst_rx) overrun_q <= 1'b1;
        end
    end

    assign rx_ready  = !fifo_empty;
    assign overrun   = overrun_q;
    assign stale_irq = stale_irq_q;
endmodule

// File: rtl/wrx_chk.sv
module wrx_chk (
    input logic       clk,
    input logic       rst,
    input logic       cmd_valid,
    input logic [2:0] cmd_code,
    input logic       rd_en,
    input logic       cmd_rst_rx,
    input logic       rx_ready,
    input logic       overrun,
    input logic       stale_irq,
    input logic       xfer_done,
    input logic       snap_nz,
    input logic       rx_byte_valid,
    input logic       fifo_full
);
    import wrx_pkg::*;

    AST_OVR_CAUSE: assert property (@(posedge clk) disable iff (rst)
        $rose(overrun) |-> $past(rx_byte_valid && fifo_full)); // R9

    AST_OVR_CLEAR: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && cmd_code == CMD_RST_ERR) |=> !overrun); // R9

    AST_OVR_HOLD: assert property (@(posedge clk) disable iff (rst)
        (overrun && !(cmd_valid && cmd_code == CMD_RST_ERR)) |=> overrun); // R9

    AST_STALE_WITH_END: assert property (@(posedge clk) disable iff (rst)
        $rose(stale_irq) |-> xfer_done); // R5

    AST_STALE_CLEAR: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && cmd_code == CMD_STALE_CLR) |=> !stale_irq); // R7

    AST_READY_DROP: assert property (@(posedge clk) disable iff (rst)
        $fell(rx_ready) |-> $past(rd_en || cmd_rst_rx)); // R8

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
        xfer_done |=> !xfer_done); // R4

    AST_SNAP_NONZERO: assert property (@(posedge clk) disable iff (rst)
        xfer_done |-> snap_nz); // R4
endmodule

bind wrx_core wrx_chk u_chk (
    .clk           (clk),
    .rst           (rst),
    .cmd_valid     (cmd_valid),
    .cmd_code      (cmd_code),
    .rd_en         (rd_en),
    .cmd_rst_rx    (cmd_rst_rx),
    .rx_ready      (rx_ready),
    .overrun       (overrun),
    .stale_irq     (stale_irq),
    .xfer_done     (xfer_done),
    .snap_nz       (|snap_count),
    .rx_byte_valid (rx_byte_valid),
    .fifo_full     (fifo_full)
);

// File: tb/wrx_core_tb.sv
module wrx_core_tb;
    localparam int CLK_PERIOD = 10;
    localparam int DIV        = 2;
    localparam int BIT_CLKS   = 16 * DIV;
    localparam int IDLE_WAIT  = 900;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        rxd = 1'b1;
    logic        cmd_valid = 1'b0;
    logic [2:0]  cmd_code = 3'd0;
    logic        arm_valid = 1'b0;
    logic [15:0] arm_count = 16'd0;
    logic [7:0]  stale_limit = 8'd2;
    logic        rd_en = 1'b0;
    logic [31:0] rd_data;
    logic        rx_ready, overrun, stale_irq, xfer_done;
    logic [15:0] snap_count;

    int checks = 0;
    int fails  = 0;
    int done_cnt = 0;
    bit finished = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    wrx_core #(.CLKS_PER_OSR(DIV)) u_dut (
        .clk(clk), .rst(rst), .rxd(rxd), .cmd_valid(cmd_valid), .cmd_code(cmd_code),
        .arm_valid(arm_valid), .arm_count(arm_count), .stale_limit(stale_limit),
        .rd_en(rd_en), .rd_data(rd_data), .rx_ready(rx_ready), .overrun(overrun),
        .stale_irq(stale_irq), .xfer_done(xfer_done), .snap_count(snap_count)
    );

    always @(negedge clk) if (!rst && xfer_done) done_cnt++;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] pat(input int i, input int seed);
        return 8'((i * 37 + seed * 91 + 5) & 255);
    endfunction

    task automatic wait_clks(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic send_byte(input logic [7:0] b, input bit good_stop);
        @(negedge clk);
        rxd = 1'b0;
        wait_clks(BIT_CLKS);
        for (int k = 0; k < 8; k++) begin
            rxd = b[k];
            wait_clks(BIT_CLKS);
        end
        if (good_stop) begin
            rxd = 1'b1;
            wait_clks(BIT_CLKS);
        end else begin
            rxd = 1'b0;
            wait_clks(24);
            rxd = 1'b1;
            wait_clks(BIT_CLKS);
        end
    endtask

    task automatic command(input logic [2:0] c);
        @(negedge clk);
        cmd_valid = 1'b1;
        cmd_code  = c;
        @(negedge clk);
        cmd_valid = 1'b0;
        cmd_code  = 3'd0;
    endtask

    task automatic arm(input int n);
        command(3'd4);
        command(3'd5);
        @(negedge clk);
        arm_valid = 1'b1;
        arm_count = 16'(n);
        @(negedge clk);
        arm_valid = 1'b0;
        command(3'd3);
    endtask

    task automatic pop_word(input string tag, input logic [31:0] exp);
        @(negedge clk);
        chk({tag, " ready"}, {31'd0, rx_ready}, 32'd1);
        chk({tag, " word"}, rd_data, exp);
        rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    // Transfer of n characters, closed either by count or by the idle timeout.
    task automatic run_xfer(input int n, input int seed, input bit by_count);
        int d0;
        logic [31:0] w;
        d0 = done_cnt;
        arm(by_count ? n : 1000);
        for (int i = 0; i < n; i++) send_byte(pat(i, seed), 1'b1);
        wait_clks(by_count ? 20 : IDLE_WAIT);
        chk(by_count ? "R4 close count" : "R5 close count", 32'(done_cnt - d0), 32'd1);
        chk(by_count ? "R4 snapshot" : "R5 snapshot", 32'(snap_count), 32'(n));
        chk(by_count ? "R4 no stale flag" : "R5 stale flag", {31'd0, stale_irq},
            by_count ? 32'd0 : 32'd1);
        for (int k = 0; k < (n + 3) / 4; k++) begin
            w = '0;
            for (int j = 0; j < 4; j++)
                if (4 * k + j < n) w[8*j +: 8] = pat(4 * k + j, seed);
            pop_word(by_count ? "R3 R4 packed" : "R3 R5 packed", w);
        end
        chk("R8 drained", {31'd0, rx_ready}, 32'd0);
        if (!by_count) begin
            wait_clks(IDLE_WAIT);
            chk("R7 sticky", {31'd0, stale_irq}, 32'd1);
            command(3'd5);
            chk("R7 cleared", {31'd0, stale_irq}, 32'd0);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            fails++;
            checks++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        int d0;
        wait_clks(5);
        rst = 1'b0;
        wait_clks(2);
        // R11 reset state
        chk("R11 rx_ready", {31'd0, rx_ready}, 32'd0);
        chk("R11 overrun", {31'd0, overrun}, 32'd0);
        chk("R11 stale_irq", {31'd0, stale_irq}, 32'd0);
        chk("R11 xfer_done", {31'd0, xfer_done}, 32'd0);
        chk("R11 snap", 32'(snap_count), 32'd0);

        // R1 R3 R4 count-closed transfers, full and partial words
        run_xfer(8, 1, 1'b1);
        wait_clks(IDLE_WAIT);
        chk("R4 no later stale", {31'd0, stale_irq}, 32'd0);
        run_xfer(6, 2, 1'b1);
        run_xfer(1, 3, 1'b1);

        // R5 R3 R7 timeout-closed transfers across every lane fill
        for (int n = 1; n <= 7; n++) run_xfer(n, 10 + n, 1'b0);

        // R6 timeout disabled, then enabled
        command(3'd4);
        d0 = done_cnt;
        send_byte(8'hA5, 1'b1);
        send_byte(8'h3C, 1'b1);
        wait_clks(IDLE_WAIT);
        chk("R6 no word while disabled", {31'd0, rx_ready}, 32'd0);
        chk("R6 no flag while disabled", {31'd0, stale_irq}, 32'd0);
        chk("R6 no close while disabled", 32'(done_cnt - d0), 32'd0);
        command(3'd3);
        wait_clks(IDLE_WAIT);
        chk("R6 flag after enable", {31'd0, stale_irq}, 32'd1);
        chk("R6 snapshot", 32'(snap_count), 32'd2);
        pop_word("R6", 32'h0000_3CA5);
        command(3'd5);

        // R2 glitch and bad stop bit
        d0 = done_cnt;
        @(negedge clk);
        rxd = 1'b0;
        wait_clks(8);
        rxd = 1'b1;
        wait_clks(IDLE_WAIT);
        chk("R2 glitch no word", {31'd0, rx_ready}, 32'd0);
        chk("R2 glitch no close", 32'(done_cnt - d0), 32'd0);
        send_byte(8'h5A, 1'b0);
        wait_clks(IDLE_WAIT);
        chk("R2 bad stop no word", {31'd0, rx_ready}, 32'd0);
        chk("R2 bad stop no close", 32'(done_cnt - d0), 32'd0);
        send_byte(8'h81, 1'b1);
        wait_clks(IDLE_WAIT);
        pop_word("R2 recovery", 32'h0000_0081);
        command(3'd5);

        // R9 R8 R10 overrun, ordering, flush
        command(3'd4);
        for (int i = 0; i < 16; i++) send_byte(pat(i, 50), 1'b1);
        chk("R9 no overrun at full", {31'd0, overrun}, 32'd0);
        send_byte(8'hEE, 1'b1);
        chk("R9 overrun set", {31'd0, overrun}, 32'd1);
        pop_word("R8 oldest", {pat(3, 50), pat(2, 50), pat(1, 50), pat(0, 50)});
        pop_word("R8 second", {pat(7, 50), pat(6, 50), pat(5, 50), pat(4, 50)});
        command(3'd1);
        wait_clks(2);
        chk("R10 flush empties", {31'd0, rx_ready}, 32'd0);
        chk("R10 overrun kept", {31'd0, overrun}, 32'd1);
        d0 = done_cnt;
        command(3'd3);
        wait_clks(IDLE_WAIT);
        chk("R10 partial discarded", {31'd0, rx_ready}, 32'd0);
        chk("R10 count discarded", 32'(done_cnt - d0), 32'd0);
        wait_clks(IDLE_WAIT);
        chk("R9 overrun sticky", {31'd0, overrun}, 32'd1);
        command(3'd2);
        chk("R9 overrun cleared", {31'd0, overrun}, 32'd0);

        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule